// File: doc/BRIEF.md
# DRAM Training Command Sequencer

This block replays a short, software-built list of raw DRAM commands onto a command bus. It is meant for memory training, where firmware must issue hand-picked activate, read, write or precharge commands with chosen gaps between them. Software fills up to four slots through a simple word-addressed write port. It then writes a control word that carries the number of commands and a start bit.

Each slot holds four things: a row/column address, a bank address, a target rank, and the three active-low strobes RAS, CAS and WE. It also holds a wait count for the cooldown that follows the command. Once started, the engine drives slot 0, then slot 1 and so on up to the last programmed slot. Each command lasts exactly one cycle and the bus sits at NOP during the wait. A one-cycle done pulse marks the end of the final wait. The rank field is decoded to a one-hot, active-low chip select that is driven only in the command cycle.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset the outputs are idle: busy and done are low, all three strobes are high, every chip select is high, and the bank and address outputs are zero.
- R2: The write port uses word index `wr_addr` as follows (shown for four slots):
  - Index s (0..3) is the address word of slot s, with the address in bits 15:0, the bank in bits 22:20 and the rank in bits 25:24.
  - Index 4+s is the command word of slot s, with RAS_n in bit 0, CAS_n in bit 1 and WE_n in bit 2.
  - Index 8+s is the wait word of slot s, with the wait count in bits 31:16.
  - Index 12 is the control word.
- R3: A control write starts a run only when bit 0 is set and the engine is idle. The number of commands n is taken from bits 19:16, which hold (n-1)*4, so bits 17:16 are ignored. A control write with bit 0 clear has no effect.
- R4: Commands are driven in slot order, starting with slot 0. Each command is driven for exactly one cycle. Slot k is driven in cycle C(k) after the edge that accepts the start, where C(0)=0 and C(k+1)=C(k)+1+wait(k).
- R5: After each command the bus holds NOP for exactly that slot's wait count of cycles. During NOP the strobes are high, every chip select is high, and the bank and address outputs are zero. A wait of zero makes the next command follow on the next cycle.
- R6: In a command cycle exactly one chip select is low, namely bit r for rank r. Outside command cycles all chip selects are high.
- R7: Busy is high from the cycle after the start is accepted through the last cycle of the final wait. Busy is low in the cycle where done is high.
- R8: Done is high for exactly one cycle, the cycle that follows the final command's wait.
- R9: Writes to slot words while busy is high are ignored. A later run replays the values that were held before the run began.
- R10: A control write with bit 0 set while busy is high neither restarts the run nor changes its command count.
- R11: Only slots 0 through n-1 are executed, and then the run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word index |
| wr_data | input | 32 | Register write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_bank | output | 3 | Bank address |
| cmd_addr | output | 16 | Row/column address |
| cmd_cs_n | output | 4 | Per-rank chip select, active low |

## Verification
The start write is captured at a clock edge, and slot 0 appears on the bus in the cycle that edge opens. Slot k appears 1+wait(k-1) cycles after slot k-1. Done and the drop of busy arrive together, sum(1+wait) cycles after the accepting edge, and done falls again one cycle later. The bench builds that schedule from its own copy of the slot contents. It then compares every output at the falling edge of each cycle, so all registers have settled before it samples. Writes made during a run are also driven at falling edges, which puts their capture edge at a known point inside the running schedule.

// File: rtl/dcs_pkg.sv
`timescale 1ns/1ps
package dcs_pkg;
   // field positions that software relies on
   localparam int ADDR_LSB  = 0;
   localparam int BANK_LSB  = 20;
   localparam int RANK_LSB  = 24;
   localparam int RAS_BIT   = 0;
   localparam int CAS_BIT   = 1;
   localparam int WE_BIT    = 2;
   localparam int WAIT_LSB  = 16;
   localparam int START_BIT = 0;
   localparam int CNT_FLD   = 16;   // count field holds (n-1)*4
   localparam int CNT_LSB   = CNT_FLD + 2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMD  = 2'd1,
      ST_COOL = 2'd2
   } dcs_state_e;

   function automatic int unsigned cmd_base(input int unsigned n);
      return n;
   endfunction
   function automatic int unsigned wait_base(input int unsigned n);
      return 2 * n;
   endfunction
   function automatic int unsigned ctrl_index(input int unsigned n);
      return 3 * n;
   endfunction
endpackage

// File: rtl/dcs_slot_bank.sv
`timescale 1ns/1ps
module dcs_slot_bank
   import dcs_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int ADDR_W    = 16,
   parameter int BA_W      = 3,
   parameter int RANK_W    = 2,
   parameter int WAIT_W    = 16,
   parameter int REG_AW    = 4,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [REG_AW-1:0] wr_addr_i,
   input  logic [31:0]       wr_data_i,
   input  logic              lock_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic [BA_W-1:0]   rd_bank_o,
   output logic [RANK_W-1:0] rd_rank_o,
   output logic [2:0]        rd_cmd_o,
   output logic [WAIT_W-1:0] rd_wait_o
);
   logic [NUM_SLOTS-1:0][ADDR_W-1:0] addr_q;
   logic [NUM_SLOTS-1:0][BA_W-1:0]   bank_q;
   logic [NUM_SLOTS-1:0][RANK_W-1:0] rank_q;
   logic [NUM_SLOTS-1:0][2:0]        cmd_q;
   logic [NUM_SLOTS-1:0][WAIT_W-1:0] wait_q;

   logic wr_ok;
   assign wr_ok = wr_i && !lock_i;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic hit_a, hit_c, hit_w;
      assign hit_a = wr_ok && (wr_addr_i == REG_AW'(s));
      assign hit_c = wr_ok && (wr_addr_i == REG_AW'(cmd_base(NUM_SLOTS) + s));
      assign hit_w = wr_ok && (wr_addr_i == REG_AW'(wait_base(NUM_SLOTS) + s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_q[s] <= '0;
            bank_q[s] <= '0;
            rank_q[s] <= '0;
            cmd_q[s]  <= 3'b111;
            wait_q[s] <= '0;
         end else begin
            if (hit_a) begin
               addr_q[s] <= wr_data_i[ADDR_LSB +: ADDR_W];
               bank_q[s] <= wr_data_i[BANK_LSB +: BA_W];
               rank_q[s] <= wr_data_i[RANK_LSB +: RANK_W];
            end
            if (hit_c) begin
               cmd_q[s] <= {wr_data_i[WE_BIT], wr_data_i[CAS_BIT], wr_data_i[RAS_BIT]};
            end
            if (hit_w) begin
               wait_q[s] <= wr_data_i[WAIT_LSB +: WAIT_W];
            end
         end
      end
   end

   assign rd_addr_o = addr_q[rd_idx_i];
   assign rd_bank_o = bank_q[rd_idx_i];
   assign rd_rank_o = rank_q[rd_idx_i];
   assign rd_cmd_o  = cmd_q[rd_idx_i];
   assign rd_wait_o = wait_q[rd_idx_i];

   AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |=> ($stable(addr_q) && $stable(bank_q) && $stable(rank_q)
                  && $stable(cmd_q) && $stable(wait_q))); // R9
endmodule

// File: rtl/dcs_engine.sv
`timescale 1ns/1ps
module dcs_engine
   import dcs_pkg::*;
#(
   parameter int IDX_W  = 2,
   parameter int WAIT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [IDX_W-1:0]  last_i,
   input  logic [WAIT_W-1:0] wait_i,
   output logic              busy_o,
   output logic              fire_o,
   output logic              done_o,
   output logic [IDX_W-1:0]  idx_o
);
   dcs_state_e        state_q;
   logic [IDX_W-1:0]  idx_q, last_q;
   logic [WAIT_W-1:0] cnt_q;
   logic              done_q;
   logic              advance;

   assign advance = ((state_q == ST_CMD) && (wait_i == '0)) ||
                    ((state_q == ST_COOL) && (cnt_q == WAIT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         last_q  <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (advance) begin
            if (idx_q == last_q) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end else begin
               idx_q   <= idx_q + 1'b1;
               state_q <= ST_CMD;
            end
         end else begin
            unique case (state_q)
               ST_IDLE: if (start_i) begin
                  state_q <= ST_CMD;
                  idx_q   <= '0;
                  last_q  <= last_i;
               end
               ST_CMD: begin
                  cnt_q   <= wait_i;
                  state_q <= ST_COOL;
               end
               ST_COOL: cnt_q <= cnt_q - 1'b1;
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign fire_o = (state_q == ST_CMD);
   assign done_o = done_q;
   assign idx_o  = idx_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R8
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o))); // R7
   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (idx_q <= last_q)); // R11
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(last_q)); // R10
endmodule

// File: rtl/dcs_cs_decode.sv
`timescale 1ns/1ps
module dcs_cs_decode #(
   parameter int NUM_RANKS = 4,
   localparam int RANK_W   = $clog2(NUM_RANKS)
) (
   input  logic                 fire_i,
   input  logic [RANK_W-1:0]    rank_i,
   output logic [NUM_RANKS-1:0] cs_n_o
);
   for (genvar r = 0; r < NUM_RANKS; r++) begin : g_cs
      assign cs_n_o[r] = !(fire_i && (rank_i == RANK_W'(r)));
   end
endmodule

// File: rtl/dram_cmd_seq.sv
`timescale 1ns/1ps
module dram_cmd_seq
   import dcs_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int ADDR_W    = 16,
   parameter int BA_W      = 3,
   parameter int NUM_RANKS = 4,
   parameter int WAIT_W    = 16,
   localparam int IDX_W    = $clog2(NUM_SLOTS),
   localparam int RANK_W   = $clog2(NUM_RANKS),
   localparam int REG_AW   = $clog2(3 * NUM_SLOTS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_AW-1:0]    wr_addr,
   input  logic [31:0]          wr_data,
   output logic                 busy,
   output logic                 done,
   output logic                 cmd_ras_n,
   output logic                 cmd_cas_n,
   output logic                 cmd_we_n,
   output logic [BA_W-1:0]      cmd_bank,
   output logic [ADDR_W-1:0]    cmd_addr,
   output logic [NUM_RANKS-1:0] cmd_cs_n
);
   // elaboration-time parameter checks
   if (NUM_SLOTS != 2 && NUM_SLOTS != 4) begin : g_bad_slots
      $error("NUM_SLOTS must be 2 or 4");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must be 1..16");
   end
   if (BA_W < 1 || BA_W > 3) begin : g_bad_ba
      $error("BA_W must be 1..3");
   end
   if (NUM_RANKS != 2 && NUM_RANKS != 4) begin : g_bad_rank
      $error("NUM_RANKS must be 2 or 4");
   end
   if (WAIT_W < 1 || WAIT_W > 16) begin : g_bad_wait
      $error("WAIT_W must be 1..16");
   end

   logic              start, fire, lock;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] s_addr;
   logic [BA_W-1:0]   s_bank;
   logic [RANK_W-1:0] s_rank;
   logic [2:0]        s_cmd;
   logic [WAIT_W-1:0] s_wait;
   logic              unused_data;

   assign unused_data = ^wr_data;
   assign start = wr_en && (wr_addr == REG_AW'(ctrl_index(NUM_SLOTS)))
                  && wr_data[START_BIT];

   dcs_slot_bank #(
      .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .BA_W(BA_W),
      .RANK_W(RANK_W), .WAIT_W(WAIT_W), .REG_AW(REG_AW)
   ) bank_i (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .lock_i(lock), .rd_idx_i(idx),
      .rd_addr_o(s_addr), .rd_bank_o(s_bank), .rd_rank_o(s_rank),
      .rd_cmd_o(s_cmd), .rd_wait_o(s_wait)
   );

   dcs_engine #(.IDX_W(IDX_W), .WAIT_W(WAIT_W)) eng_i (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .last_i(wr_data[CNT_LSB +: IDX_W]), .wait_i(s_wait),
      .busy_o(lock), .fire_o(fire), .done_o(done), .idx_o(idx)
   );

   dcs_cs_decode #(.NUM_RANKS(NUM_RANKS)) cs_i (
      .fire_i(fire), .rank_i(s_rank), .cs_n_o(cmd_cs_n)
   );

   assign busy      = lock;
   assign cmd_ras_n = fire ? s_cmd[0] : 1'b1;
   assign cmd_cas_n = fire ? s_cmd[1] : 1'b1;
   assign cmd_we_n  = fire ? s_cmd[2] : 1'b1;
   assign cmd_bank  = fire ? s_bank : '0;
   assign cmd_addr  = fire ? s_addr : '0;

   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cmd_cs_n)); // R6
   AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (&cmd_cs_n && cmd_ras_n && cmd_cas_n && cmd_we_n)); // R5
endmodule

// File: tb/dram_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module dram_cmd_seq_tb_top;
   localparam int CTRL = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        busy, done, cmd_ras_n, cmd_cas_n, cmd_we_n;
   logic [2:0]  cmd_bank;
   logic [15:0] cmd_addr;
   logic [3:0]  cmd_cs_n;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   // bench copy of slot contents
   logic [15:0] m_addr [4];
   logic [2:0]  m_ba   [4];
   logic [1:0]  m_rank [4];
   logic [2:0]  m_cmd  [4];
   int          m_wait [4];

   always #2 clk = ~clk;

   dram_cmd_seq dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .done(done), .cmd_ras_n(cmd_ras_n),
      .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_bank(cmd_bank),
      .cmd_addr(cmd_addr), .cmd_cs_n(cmd_cs_n)
   );

   localparam logic [27:0] IDLE_VEC = {1'b0, 1'b0, 3'b111, 3'b000, 16'h0, 4'hf};

   function automatic logic [27:0] act_vec();
      return {busy, done, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_bank, cmd_addr, cmd_cs_n};
   endfunction

   function automatic int total_cycles(input int n);
      int t = 0;
      for (int k = 0; k < n; k++) t += 1 + m_wait[k];
      return t;
   endfunction

   // expected outputs c cycles after the accepting edge
   function automatic logic [27:0] exp_vec(input int n, input int c);
      int t = 0;
      for (int k = 0; k < n; k++) begin
         if (c == t)
            return {1'b1, 1'b0, m_cmd[k][0], m_cmd[k][1], m_cmd[k][2],
                    m_ba[k], m_addr[k], ~(4'b0001 << m_rank[k])};
         if (c < t + 1 + m_wait[k])
            return {1'b1, 1'b0, 3'b111, 3'b000, 16'h0, 4'hf};
         t += 1 + m_wait[k];
      end
      if (c == t) return {1'b0, 1'b1, 3'b111, 3'b000, 16'h0, 4'hf};
      return IDLE_VEC;
   endfunction

   task automatic check(input string tag, input logic [27:0] got, input logic [27:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic program_slot(input int k, input logic [15:0] a, input logic [2:0] ba,
                               input logic [1:0] rk, input logic [2:0] cm, input int w);
      reg_write(4'(k), {6'b0, rk, 1'b0, ba, 4'b0, a});
      reg_write(4'(4 + k), {29'b0, cm});
      reg_write(4'(8 + k), {w[15:0], 16'h0});
      m_addr[k] = a; m_ba[k] = ba; m_rank[k] = rk; m_cmd[k] = cm; m_wait[k] = w;
   endtask

   // start a run of n commands; junk fills the ignored low count bits
   task automatic run_seq(input int n, input logic [1:0] junk, input bit inject, input string tag);
      int total = total_cycles(n);
      logic [31:0] ctl = 32'h1 | (32'(n - 1) << 18) | (32'(junk) << 16);
      reg_write(CTRL, ctl);
      for (int c = 0; c <= total + 1; c++) begin
         string t;
         logic [27:0] e = exp_vec(n, c);
         if (c < total) t = (e[25] == 1'b1 && e[24] == 1'b1 && e[23] == 1'b1)
                            ? {tag, " R5 R7 cooldown"} : {tag, " R2 R4 R6 command"};
         else if (c == total) t = {tag, " R7 R8 R11 done"};
         else t = {tag, " R8 after done"};
         check(t, act_vec(), e);
         if (inject && c == 1) begin
            wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h0300_BEEF;          // R9
         end else if (inject && c == 2) begin
            wr_en = 1'b1; wr_addr = CTRL; wr_data = 32'h1 | (32'(3 - (n - 1)) << 18); // R10
         end else begin
            wr_en = 1'b0;
         end
         @(negedge clk);
      end
      wr_en = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check("R1 reset state", act_vec(), IDLE_VEC);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", act_vec(), IDLE_VEC);

      // directed: four commands back to back, all ranks
      program_slot(0, 16'h1234, 3'd1, 2'd0, 3'b011, 0);
      program_slot(1, 16'hABCD, 3'd7, 2'd1, 3'b101, 0);
      program_slot(2, 16'h0001, 3'd2, 2'd2, 3'b100, 0);
      program_slot(3, 16'hFFFF, 3'd5, 2'd3, 3'b010, 0);
      run_seq(4, 2'b00, 1'b0, "dir b2b");

      // R3: control write with start bit clear does nothing
      reg_write(CTRL, 32'h000C_0000);
      for (int c = 0; c < 3; c++) begin
         check("R3 no start", act_vec(), IDLE_VEC);
         @(negedge clk);
      end

      // single command, zero wait, junk in ignored count bits
      run_seq(1, 2'b11, 1'b0, "dir single R3");

      // single command with a long wait
      program_slot(0, 16'h0F0F, 3'd3, 2'd2, 3'b110, 300);
      run_seq(1, 2'b01, 1'b0, "dir long wait");

      // writes during a run are ignored, then replayed unchanged
      program_slot(0, 16'h2222, 3'd4, 2'd1, 3'b001, 4);
      program_slot(1, 16'h3333, 3'd6, 2'd3, 3'b000, 2);
      run_seq(2, 2'b00, 1'b1, "R9 R10 inject");
      run_seq(2, 2'b00, 1'b0, "R9 replay");

      // constrained random runs
      for (int r = 0; r < 24; r++) begin
         int n = $urandom_range(1, 4);
         for (int k = 0; k < 4; k++)
            program_slot(k, 16'($urandom), 3'($urandom), 2'($urandom),
                         3'($urandom), $urandom_range(0, 6));
         run_seq(n, 2'($urandom), 1'b0, "rand");
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule